// File: doc/BRIEF.md
# Compressed Instruction Expander

This block takes one 16-bit compressed instruction from the integer RV32C subset and rewrites it as the 32-bit base-ISA instruction that does the same thing, so an ordinary 32-bit decoder downstream needs no knowledge of the short encodings. It sits between fetch and decode: the fetch side presents a halfword with a valid strobe, and one clock later the expanded word appears with its own valid strobe and an illegal flag.

All eight short formats are decoded: register-register (CR), immediate (CI), stack-relative store (CSS), wide immediate (CIW), load (CL), store (CS), branch/arithmetic (CB) and jump (CJ). Three-bit register fields are widened into x8–x15, scrambled immediate bits are put back in order, and sign extension always comes from instruction bit 12. Floating-point and 64-bit-only slots, reserved encodings and non-compressed words raise the illegal flag, and the expanded word is then forced to zero.

Top module: `rvc_expander`

## Requirements
- R1: An input whose bits [1:0] equal binary 11 is not a compressed instruction; it is reported illegal.
- R2: Output valid equals the input valid of the previous clock; the word and flag captured with it appear in that same cycle. A synchronous active-high reset clears output valid.
- R3: In CIW, CL, CS and CB formats, each 3-bit register field f (at [9:7] or [4:2]) expands to the 5-bit register {2'b01, f}, i.e. x8–x15; CB arithmetic uses [9:7] as both destination and first source.
- R4: In CR and CI formats the destination/first-source field is the full 5-bit value at bits [11:7], placed unchanged in bits [11:7] of the 32-bit word; the second source in CR and CSS is the 5-bit value at bits [6:2].
- R5: Stack-relative word loads (quadrant 10, funct3 010) and stores (quadrant 10, funct3 110) use x2 as base and a zero-extended offset scaled by 4; a load with destination x0 is illegal.
- R6: The add-to-stack-pointer form (quadrant 00, funct3 000) produces addi rd', x2, imm with an 8-bit zero-extended immediate scaled by 4; a zero immediate, including the all-zero halfword, is illegal.
- R7: Signed immediates (addi, li, andi, lui, add-16-to-sp, branches, jumps) are sign-extended from instruction bit 12; a zero immediate for lui or add-16-to-sp is illegal.
- R8: funct3 101 of quadrant 01 becomes jal x0, funct3 001 becomes jal x1; funct3 110/111 become beq/bne rs1', x0.
- R9: Quadrant 10 funct3 100 gives: bit12=0, rs2=0 → jalr x0,0(rs1) (illegal when rs1=0); bit12=0, rs2≠0 → add rd,x0,rs2; bit12=1, both zero → ebreak (32'h00100073); bit12=1, rs2=0 → jalr x1,0(rs1); otherwise add rd,rd,rs2.
- R10: Shifts place the 5-bit amount in bits [24:20]; arithmetic right shift carries 0100000 in bits [31:25]; a shift amount with bit 12 set is illegal.
- R11: Floating-point and reserved slots (quadrant 00 funct3 001, 011, 100, 101, 111; quadrant 10 funct3 001, 011, 101, 111) and the quadrant 01 register-register group with bit 12 set are illegal.
- R12: Whenever the illegal flag is set the output word is zero; every legal output word ends in binary 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Halfword on in_half is to be expanded |
| in_half | input | 16 | Compressed instruction |
| out_valid | output | 1 | Registered result is present |
| out_word | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal | output | 1 | Input is not a supported compressed instruction |

## Verification
The bench aims at the immediates whose bits are most shuffled: jump offsets at both ends of their range, branch offsets with bit 12 set, and maximum scaled load, store and stack-add offsets; a design that misplaced one bit would return a word that differs in one immediate bit. It covers the reserved encodings that sit next to legal ones (zero stack-add immediate, the all-zero halfword, jump-register through x0, load into x0, shift amounts with bit 12 set), where a loose decoder would emit a plausible instruction instead of flagging it. Register widening is checked with x8 and x15 on every compact format, so a missing 01 prefix shows up as a low register number.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  localparam int CW = 16;
  localparam int XW = 32;
  localparam int RW = 5;
  localparam int PW = 3;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  localparam logic [XW-1:0] WORD_EBREAK = 32'h0010_0073;

  localparam logic [RW-1:0] REG_ZERO = 5'd0;
  localparam logic [RW-1:0] REG_RA   = 5'd1;
  localparam logic [RW-1:0] REG_SP   = 5'd2;

  typedef struct packed {
    logic [XW-1:0] word;
    logic          illegal;
  } xlat_t;

  typedef struct packed {
    logic [RW-1:0] rd_full;
    logic [RW-1:0] rs2_full;
    logic [RW-1:0] rs1_p;
    logic [RW-1:0] rs2_p;
    logic [11:0]   imm_ci;
    logic [11:0]   imm_16sp;
    logic [11:0]   imm_4spn;
    logic [11:0]   imm_lw;
    logic [11:0]   imm_lwsp;
    logic [11:0]   imm_swsp;
    logic [19:0]   imm_lui;
    logic [20:0]   imm_j;
    logic [12:0]   imm_b;
    logic [5:0]    shamt;
  } fields_t;

  localparam xlat_t XLAT_BAD = '{word: '0, illegal: 1'b1};

  function automatic logic [RW-1:0] widen_reg(input logic [PW-1:0] f);
    return {2'b01, f};
  endfunction

  function automatic xlat_t enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                  input logic [2:0] f3, input logic [4:0] rd,
                                  input logic [6:0] op);
    return '{word: {imm, rs1, f3, rd, op}, illegal: 1'b0};
  endfunction

  function automatic xlat_t enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                  input logic [4:0] rs1, input logic [2:0] f3,
                                  input logic [4:0] rd, input logic [6:0] op);
    return '{word: {f7, rs2, rs1, f3, rd, op}, illegal: 1'b0};
  endfunction

  function automatic xlat_t enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                  input logic [4:0] rs1, input logic [2:0] f3,
                                  input logic [6:0] op);
    return '{word: {imm[11:5], rs2, rs1, f3, imm[4:0], op}, illegal: 1'b0};
  endfunction

  function automatic xlat_t enc_b(input logic [12:0] imm, input logic [4:0] rs2,
                                  input logic [4:0] rs1, input logic [2:0] f3);
    return '{word: {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH},
             illegal: 1'b0};
  endfunction

  function automatic xlat_t enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return '{word: {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL},
             illegal: 1'b0};
  endfunction

  function automatic xlat_t enc_u(input logic [19:0] imm, input logic [4:0] rd);
    return '{word: {imm, rd, OPC_LUI}, illegal: 1'b0};
  endfunction

endpackage

// File: rtl/rvc_field_unpack.sv
module rvc_field_unpack
  import rvc_pkg::*;
(
  input  logic [CW-1:0] inst,
  output fields_t       fld
);

  logic sgn;
  assign sgn = inst[12];

  always_comb begin
    fld.rd_full  = inst[11:7];
    fld.rs2_full = inst[6:2];
    fld.rs1_p    = widen_reg(inst[9:7]);
    fld.rs2_p    = widen_reg(inst[4:2]);
    fld.shamt    = {inst[12], inst[6:2]};

    // six-bit signed immediate of the CI format
    fld.imm_ci   = {{6{sgn}}, inst[12], inst[6:2]};
    // upper-immediate: bits 17:12 of the value, extended to 20 bits
    fld.imm_lui  = {{14{sgn}}, inst[12], inst[6:2]};
    // stack adjust in multiples of 16
    fld.imm_16sp = {{2{sgn}}, inst[12], inst[4:3], inst[5], inst[2], inst[6], 4'b0000};
    // unsigned stack-relative address, multiples of 4
    fld.imm_4spn = {2'b00, inst[10:7], inst[12:11], inst[5], inst[6], 2'b00};
    fld.imm_lw   = {5'b00000, inst[5], inst[12:10], inst[6], 2'b00};
    fld.imm_lwsp = {4'b0000, inst[3:2], inst[12], inst[6:4], 2'b00};
    fld.imm_swsp = {4'b0000, inst[8:7], inst[12:9], 2'b00};
    fld.imm_j    = {{10{sgn}}, inst[12], inst[8], inst[10:9], inst[6], inst[7],
                    inst[2], inst[11], inst[5:3], 1'b0};
    fld.imm_b    = {{5{sgn}}, inst[12], inst[6:5], inst[2], inst[11:10],
                    inst[4:3], 1'b0};
  end

endmodule

// File: rtl/rvc_q0_expand.sv
module rvc_q0_expand
  import rvc_pkg::*;
(
  input  logic [CW-1:0] inst,
  input  fields_t       fld,
  output xlat_t         res
);

  logic [2:0] f3;
  assign f3 = inst[15:13];

  always_comb begin
    res = XLAT_BAD;
    unique case (f3)
      3'b000: begin
        if (fld.imm_4spn != 12'd0)
          res = enc_i(fld.imm_4spn, REG_SP, 3'b000, fld.rs2_p, OPC_OPIMM);
      end
      3'b010: res = enc_i(fld.imm_lw, fld.rs1_p, 3'b010, fld.rs2_p, OPC_LOAD);
      3'b110: res = enc_s(fld.imm_lw, fld.rs2_p, fld.rs1_p, 3'b010, OPC_STORE);
      default: res = XLAT_BAD;
    endcase
  end

endmodule

// File: rtl/rvc_q1_expand.sv
module rvc_q1_expand
  import rvc_pkg::*;
(
  input  logic [CW-1:0] inst,
  input  fields_t       fld,
  output xlat_t         res
);

  logic [2:0] f3;
  logic [1:0] grp;
  logic [1:0] sub;
  logic       b12;
  logic       ci_zero;

  assign f3      = inst[15:13];
  assign grp     = inst[11:10];
  assign sub     = inst[6:5];
  assign b12     = inst[12];
  assign ci_zero = ({inst[12], inst[6:2]} == 6'd0);

  xlat_t alu_res;

  // quadrant 01 funct3 100: shifts, andi and register-register group
  always_comb begin
    alu_res = XLAT_BAD;
    unique case (grp)
      2'b00: if (!b12)
        alu_res = enc_i({7'b0000000, fld.shamt[4:0]}, fld.rs1_p, 3'b101,
                        fld.rs1_p, OPC_OPIMM);
      2'b01: if (!b12)
        alu_res = enc_i({7'b0100000, fld.shamt[4:0]}, fld.rs1_p, 3'b101,
                        fld.rs1_p, OPC_OPIMM);
      2'b10: alu_res = enc_i(fld.imm_ci, fld.rs1_p, 3'b111, fld.rs1_p, OPC_OPIMM);
      default: if (!b12) begin
        unique case (sub)
          2'b00: alu_res = enc_r(7'b0100000, fld.rs2_p, fld.rs1_p, 3'b000,
                                 fld.rs1_p, OPC_OP);
          2'b01: alu_res = enc_r(7'b0000000, fld.rs2_p, fld.rs1_p, 3'b100,
                                 fld.rs1_p, OPC_OP);
          2'b10: alu_res = enc_r(7'b0000000, fld.rs2_p, fld.rs1_p, 3'b110,
                                 fld.rs1_p, OPC_OP);
          default: alu_res = enc_r(7'b0000000, fld.rs2_p, fld.rs1_p, 3'b111,
                                   fld.rs1_p, OPC_OP);
        endcase
      end
    endcase
  end

  always_comb begin
    res = XLAT_BAD;
    unique case (f3)
      3'b000: res = enc_i(fld.imm_ci, fld.rd_full, 3'b000, fld.rd_full, OPC_OPIMM);
      3'b001: res = enc_j(fld.imm_j, REG_RA);
      3'b010: res = enc_i(fld.imm_ci, REG_ZERO, 3'b000, fld.rd_full, OPC_OPIMM);
      3'b011: begin
        if (fld.rd_full == REG_SP) begin
          if (!ci_zero)
            res = enc_i(fld.imm_16sp, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
        end else if (!ci_zero) begin
          res = enc_u(fld.imm_lui, fld.rd_full);
        end
      end
      3'b100: res = alu_res;
      3'b101: res = enc_j(fld.imm_j, REG_ZERO);
      3'b110: res = enc_b(fld.imm_b, REG_ZERO, fld.rs1_p, 3'b000);
      default: res = enc_b(fld.imm_b, REG_ZERO, fld.rs1_p, 3'b001);
    endcase
  end

endmodule

// File: rtl/rvc_q2_expand.sv
module rvc_q2_expand
  import rvc_pkg::*;
(
  input  logic [CW-1:0] inst,
  input  fields_t       fld,
  output xlat_t         res
);

  logic [2:0] f3;
  logic       b12;
  logic       rd_nz;
  logic       rs2_nz;

  assign f3     = inst[15:13];
  assign b12    = inst[12];
  assign rd_nz  = (fld.rd_full != REG_ZERO);
  assign rs2_nz = (fld.rs2_full != REG_ZERO);

  xlat_t cr_res;

  // funct3 100: jumps through a register, moves, adds, breakpoint
  always_comb begin
    cr_res = XLAT_BAD;
    if (!b12) begin
      if (rs2_nz)
        cr_res = enc_r(7'b0000000, fld.rs2_full, REG_ZERO, 3'b000, fld.rd_full, OPC_OP);
      else if (rd_nz)
        cr_res = enc_i(12'd0, fld.rd_full, 3'b000, REG_ZERO, OPC_JALR);
    end else begin
      if (rs2_nz)
        cr_res = enc_r(7'b0000000, fld.rs2_full, fld.rd_full, 3'b000, fld.rd_full, OPC_OP);
      else if (rd_nz)
        cr_res = enc_i(12'd0, fld.rd_full, 3'b000, REG_RA, OPC_JALR);
      else
        cr_res = '{word: WORD_EBREAK, illegal: 1'b0};
    end
  end

  always_comb begin
    res = XLAT_BAD;
    unique case (f3)
      3'b000: if (!b12)
        res = enc_i({7'b0000000, fld.shamt[4:0]}, fld.rd_full, 3'b001,
                    fld.rd_full, OPC_OPIMM);
      3'b010: if (rd_nz)
        res = enc_i(fld.imm_lwsp, REG_SP, 3'b010, fld.rd_full, OPC_LOAD);
      3'b100: res = cr_res;
      3'b110: res = enc_s(fld.imm_swsp, fld.rs2_full, REG_SP, 3'b010, OPC_STORE);
      default: res = XLAT_BAD;
    endcase
  end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] in_half,
  output logic          out_valid,
  output logic [XW-1:0] out_word,
  output logic          out_illegal
);

  fields_t fld;
  xlat_t   q_res [3];
  xlat_t   sel;

  rvc_field_unpack u_unpack (.inst(in_half), .fld(fld));

  rvc_q0_expand u_q0 (.inst(in_half), .fld(fld), .res(q_res[0]));
  rvc_q1_expand u_q1 (.inst(in_half), .fld(fld), .res(q_res[1]));
  rvc_q2_expand u_q2 (.inst(in_half), .fld(fld), .res(q_res[2]));

  always_comb begin
    unique case (in_half[1:0])
      2'b00:   sel = q_res[0];
      2'b01:   sel = q_res[1];
      2'b10:   sel = q_res[2];
      default: sel = XLAT_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= sel.word;
        out_illegal <= sel.illegal;
      end
    end
  end

  assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_uncompressed_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[1:0] == 2'b11) |=> out_illegal);

  assert_zero_half_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half == '0) |=> out_illegal);

  assert_lw_regs_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[1:0] == 2'b00 && in_half[15:13] == 3'b010)
      |=> (out_word[19:18] == 2'b01 && out_word[11:10] == 2'b01));

  assert_swsp_base_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[1:0] == 2'b10 && in_half[15:13] == 3'b110)
      |=> (out_word[19:15] == REG_SP));

  assert_blank_word_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_word == '0));

  assert_legal_len_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal) |-> (out_word[1:0] == 2'b11));

endmodule

// File: tb/rvc_expander_test.sv
module rvc_expander_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  logic [32:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  rvc_expander uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal)
  );

  // 32-bit encoders
  function automatic logic [31:0] ei(input logic [11:0] imm, input logic [4:0] rs1,
                                     input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] er(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1, input logic [2:0] f3,
                                     input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] es(input logic [11:0] imm, input logic [4:0] rs2,
                                     input logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] eb(input logic [12:0] imm, input logic [4:0] rs1,
                                     input logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] ej(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6F};
  endfunction

  // 16-bit encoders
  function automatic logic [15:0] c_4spn(input logic [2:0] rdp, input logic [9:0] im);
    return {3'b000, im[5:4], im[9:6], im[2], im[3], rdp, 2'b00};
  endfunction
  function automatic logic [15:0] c_mem(input logic [2:0] f3, input logic [2:0] rp,
                                        input logic [2:0] bp, input logic [6:0] o);
    return {f3, o[5:3], bp, o[2], o[6], rp, 2'b00};
  endfunction
  function automatic logic [15:0] c_ci(input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [5:0] im);
    return {f3, im[5], rd, im[4:0], 2'b01};
  endfunction
  function automatic logic [15:0] c_16sp(input logic [9:0] im);
    return {3'b011, im[9], 5'd2, im[4], im[6], im[8:7], im[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_jmp(input logic [2:0] f3, input logic [11:0] o);
    return {f3, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_br(input logic [2:0] f3, input logic [2:0] rp,
                                       input logic [8:0] o);
    return {f3, o[8], o[4:3], rp, o[7:6], o[2:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_alu(input logic b12, input logic [1:0] g,
                                        input logic [2:0] rp, input logic [4:0] low);
    return {3'b100, b12, g, rp, low, 2'b01};
  endfunction
  function automatic logic [15:0] c_lwsp(input logic [4:0] rd, input logic [7:0] o);
    return {3'b010, o[5], rd, o[4:2], o[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] c_swsp(input logic [4:0] rs2, input logic [7:0] o);
    return {3'b110, o[5:2], o[7:6], rs2, 2'b10};
  endfunction
  function automatic logic [15:0] c_cr(input logic b12, input logic [4:0] a,
                                       input logic [4:0] b);
    return {3'b100, b12, a, b, 2'b10};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual ill=%0b word=%08h expected ill=%0b word=%08h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic send(input logic [15:0] h, input logic [31:0] w, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = h;
    exp_q.push_back({1'b0, w});
    tag_q.push_back(tag);
  endtask

  task automatic send_bad(input logic [15:0] h, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = h;
    exp_q.push_back({1'b1, 32'h0});
    tag_q.push_back(tag);
  endtask

  // monitor: results appear one clock after the input is taken
  always @(negedge clk) begin
    if (mon_en && !rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", {out_illegal, out_word}, 33'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_illegal, out_word} === e, t, {out_illegal, out_word}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2: reset holds output valid low even with input valid high
    in_valid = 1'b1;
    in_half  = 16'h4501;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R2 reset clears valid", {32'h0, out_valid}, 33'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R2 idle after reset", {32'h0, out_valid}, 33'h0);
    mon_en = 1'b1;

    // R1 and R11: not compressed / reserved slots
    send_bad(16'h1237, "R1 quadrant 11");
    send_bad(16'hFFFF, "R1 all ones");
    send_bad(16'h2000, "R11 q0 funct3 001");
    send_bad(16'h8000 | 16'h0044, "R11 q0 funct3 100");
    send_bad(16'h6002, "R11 q2 funct3 011");
    send_bad(16'hE002, "R11 q2 funct3 111");
    send_bad(c_alu(1'b1, 2'b11, 3'd1, 5'b00010), "R11 q1 reg group bit12");

    // R6: stack-pointer add, zero-extended x4, zero illegal
    send(c_4spn(3'd7, 10'h3FC), ei(12'd1020, 5'd2, 3'b000, 5'd15, 7'h13), "R6 4spn max");
    send(c_4spn(3'd0, 10'h004), ei(12'd4, 5'd2, 3'b000, 5'd8, 7'h13), "R6 4spn min");
    send_bad(c_4spn(3'd3, 10'h000), "R6 4spn zero imm");
    send_bad(16'h0000, "R6 all-zero half");

    // R3: compact loads and stores widen into x8..x15
    send(c_mem(3'b010, 3'd2, 3'd5, 7'h7C), ei(12'd124, 5'd13, 3'b010, 5'd10, 7'h03), "R3 lw");
    send(c_mem(3'b110, 3'd6, 3'd0, 7'h40), es(12'd64, 5'd14, 5'd8), "R3 sw");
    send(c_mem(3'b010, 3'd7, 3'd7, 7'h04), ei(12'd4, 5'd15, 3'b010, 5'd15, 7'h03), "R3 lw x15");

    // R4 and R7: full registers, sign extension from bit 12
    send(c_ci(3'b000, 5'd5, 6'b111101), ei(12'hFFD, 5'd5, 3'b000, 5'd5, 7'h13), "R7 addi neg");
    send(c_ci(3'b000, 5'd31, 6'b011111), ei(12'd31, 5'd31, 3'b000, 5'd31, 7'h13), "R4 addi x31");
    send(c_ci(3'b010, 5'd9, 6'b100000), ei(12'hFE0, 5'd0, 3'b000, 5'd9, 7'h13), "R7 li");
    send(c_ci(3'b011, 5'd7, 6'b100001), {20'hFFFE1, 5'd7, 7'h37}, "R7 lui neg");
    send_bad(c_ci(3'b011, 5'd7, 6'b000000), "R7 lui zero");
    send(c_16sp(10'h3C0), ei(12'hFC0, 5'd2, 3'b000, 5'd2, 7'h13), "R7 addi16sp neg");
    send(c_16sp(10'h1F0), ei(12'h1F0, 5'd2, 3'b000, 5'd2, 7'h13), "R7 addi16sp pos");
    send_bad(c_16sp(10'h000), "R7 addi16sp zero");
    send(c_alu(1'b1, 2'b10, 3'd7, 5'b11111), ei(12'hFFF, 5'd15, 3'b111, 5'd15, 7'h13), "R7 andi");

    // R8: jumps and branches
    send(c_jmp(3'b101, 12'hFFE), ej(21'h1FFFFE, 5'd0), "R8 j back");
    send(c_jmp(3'b001, 12'h7FE), ej(21'h0007FE, 5'd1), "R8 jal fwd");
    send(c_jmp(3'b101, 12'h800), ej(21'h1FF800, 5'd0), "R8 j min");
    send(c_br(3'b110, 3'd0, 9'h100), eb(13'h1F00, 5'd8, 3'b000), "R8 beqz back");
    send(c_br(3'b111, 3'd7, 9'h0FE), eb(13'h00FE, 5'd15, 3'b001), "R8 bnez fwd");

    // R10: shifts
    send(c_alu(1'b0, 2'b00, 3'd1, 5'd31), ei(12'd31, 5'd9, 3'b101, 5'd9, 7'h13), "R10 srli");
    send(c_alu(1'b0, 2'b01, 3'd2, 5'd3), ei({7'b0100000, 5'd3}, 5'd10, 3'b101, 5'd10, 7'h13), "R10 srai");
    send_bad(c_alu(1'b1, 2'b00, 3'd1, 5'd1), "R10 srli bit12");
    send({3'b000, 1'b0, 5'd10, 5'd5, 2'b10}, ei(12'd5, 5'd10, 3'b001, 5'd10, 7'h13), "R10 slli");
    send_bad({3'b000, 1'b1, 5'd10, 5'd5, 2'b10}, "R10 slli bit12");

    // R3: register-register compact group
    send(c_alu(1'b0, 2'b11, 3'd0, {2'b00, 3'd4}), er(7'h20, 5'd12, 5'd8, 3'b000, 5'd8), "R3 sub");
    send(c_alu(1'b0, 2'b11, 3'd3, {2'b01, 3'd7}), er(7'h00, 5'd15, 5'd11, 3'b100, 5'd11), "R3 xor");
    send(c_alu(1'b0, 2'b11, 3'd5, {2'b10, 3'd1}), er(7'h00, 5'd9, 5'd13, 3'b110, 5'd13), "R3 or");
    send(c_alu(1'b0, 2'b11, 3'd6, {2'b11, 3'd2}), er(7'h00, 5'd10, 5'd14, 3'b111, 5'd14), "R3 and");

    // R5: stack-relative loads and stores
    send(c_lwsp(5'd31, 8'hFC), ei(12'd252, 5'd2, 3'b010, 5'd31, 7'h03), "R5 lwsp");
    send_bad(c_lwsp(5'd0, 8'h10), "R5 lwsp x0");
    send(c_swsp(5'd17, 8'hC4), es(12'hC4, 5'd17, 5'd2), "R5 swsp");

    // R9: CR group
    send(c_cr(1'b0, 5'd3, 5'd31), er(7'h00, 5'd31, 5'd0, 3'b000, 5'd3), "R9 mv");
    send(c_cr(1'b1, 5'd3, 5'd4), er(7'h00, 5'd4, 5'd3, 3'b000, 5'd3), "R9 add");
    send(c_cr(1'b0, 5'd1, 5'd0), ei(12'd0, 5'd1, 3'b000, 5'd0, 7'h67), "R9 jr");
    send(c_cr(1'b1, 5'd6, 5'd0), ei(12'd0, 5'd6, 3'b000, 5'd1, 7'h67), "R9 jalr");
    send(c_cr(1'b1, 5'd0, 5'd0), 32'h0010_0073, "R9 ebreak");
    send_bad(c_cr(1'b0, 5'd0, 5'd0), "R9 jr x0");

    @(negedge clk);
    in_valid = 1'b0;
    in_half  = 16'h0000;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R2 valid drops after stream", {32'h0, out_valid}, 33'h0);
    check(exp_q.size() == 0, "R2 every input answered",
          {1'b0, 32'(exp_q.size())}, 33'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule